// File: doc/BRIEF.md
# Interval Timer Prescaler

The block is a 14-stage binary divider that works as an interval timer. It runs from one of two tick sources: a system-clock tick or a sub-clock tick. A 4-bit interval field picks which divider stage is the timer's output tap. Each time the chosen tap goes from low to high, an interrupt pending flag is set. The interrupt request output is the flag gated by an enable bit. A second path re-times the tap to the system tick, so that downstream timers, a serial interface and a watchdog see a clean prescaler signal. A sub-clock output carries either the divided pulse stream or, when bypassed, the raw sub-clock tick.

The whole block is in one clock domain, `clk`. Both sources arrive as one-cycle enable pulses. The block has a sleep input. While sleep is high, the re-timed output is forced low and its two-flop synchronizer is held clear. The divider keeps advancing on sub-clock ticks in sleep, and it can still set the flag. The output path has two named states:
- `ST_AWAKE`: the synchronizer runs.
- `ST_SLEEP`: the synchronizer is held clear.

Transitions:
- ST_AWAKE to ST_SLEEP is taken in any cycle where `sleep` is high.
- ST_SLEEP to ST_AWAKE is taken in the first cycle where `sleep` is low. The synchronizer is cleared once more on that edge.

Software reaches two byte-wide control registers through a simple write port.
- Register at address 0: the interval field sits in bits [3:0].
- Register at address 1, bit 0: source (0 = system tick, 1 = sub-clock tick).
- Register at address 1, bit 1: interrupt request enable (1 = enabled).
- Register at address 1, bit 2: sub-clock bypass.
- Register at address 1, bit 3: write 1 to clear the pending flag. This bit is not stored.

Top module: `pit_prescaler`

## Requirements
- R1: After reset, the divider, both control registers, the pending flag and the synchronizer are cleared. As a result, the system tick is the source and `tmr_out`, `irq_flag` and `irq_req` are 0.
- R2: Address 1 bit 0 sets the source. With 0, the divider advances by one in each cycle where `sys_tick` is 1. With 1, it advances on `sub_tick` instead. The count wraps modulo 2^14.
- R3: The interval value v (address 0, bits [3:0]) selects count bit v for v from 0 to 13, so the tap period is 2^(v+1) ticks. Values 14 and 15 select count bit 13.
- R4: The pending flag is set after each advance in which the selected tap goes from 0 to 1. Writing 1 to address 1 bit 3 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R5: `irq_req` is 1 exactly when the flag is set and address 1 bit 1 is 1. The flag is set whatever the value of that enable bit.
- R6: When awake, `tmr_out` is the tap value passed through two flops. Both flops load only in cycles where `sys_tick` is 1.
- R7: While `sleep` is 1, `tmr_out` is 0 in the same cycle and both synchronizer flops are cleared. On the first edge after `sleep` falls, the flops are cleared once more.
- R8: Sleep does not stop the divider or the flag. With the sub-clock source, counting and flag setting go on during sleep.
- R9: `sub_tick_out` follows `sub_tick` when address 1 bit 2 is 1. When that bit is 0, it is the one-cycle rising pulse of the selected tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | System-clock tick enable |
| sub_tick | input | 1 | Sub-clock tick enable |
| sleep | input | 1 | Sleep request; forces the re-timed output low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select (0 interval, 1 control) |
| wr_data | input | 8 | Register write data |
| tmr_out | output | 1 | Tap re-timed to the system tick |
| irq_flag | output | 1 | Interrupt pending flag |
| irq_req | output | 1 | Flag gated by the request enable |
| sub_tick_out | output | 1 | Divided pulse or bypassed sub-clock tick |

## Verification
The corner that is hardest to reach from the ports is the rising edge of the last tap. It needs 8192 advances, and the flag must be set by that edge while the interval field holds 14 or 15. The stimulus gets there by selecting value 14 and holding `sys_tick` high for more than 16384 cycles, so the tap rises and wraps. A second hard case is a flag set during sleep together with the extra clear cycle on wake. To reach it, the stimulus switches to the sub-clock source and toggles `sleep` while random sub-clock ticks keep arriving at a short interval. Write-1-to-clear pulses are injected so that some of them coincide with tap edges.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int STAGES   = 14;
    localparam int SEL_W    = 4;
    localparam int DATA_W   = 8;
    // control register bit positions (address 1)
    localparam int B_SRC    = 0;
    localparam int B_IRQEN  = 1;
    localparam int B_BYPASS = 2;
    localparam int B_CLR    = 3;

    typedef enum logic {
        ST_AWAKE = 1'b0,
        ST_SLEEP = 1'b1
    } sync_state_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tap_rise,
    output logic [SW-1:0] interval,
    output logic          src_sub,
    output logic          irq_en,
    output logic          bypass,
    output logic          flag
);
    logic wr_iv, wr_ctl, clr_req;

    always_comb begin
        wr_iv   = wr_en && !wr_addr;
        wr_ctl  = wr_en &&  wr_addr;
        clr_req = wr_ctl && wr_data[B_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval <= '0;
            src_sub  <= 1'b0;
            irq_en   <= 1'b0;
            bypass   <= 1'b0;
        end else begin
            if (wr_iv)
                interval <= wr_data[SW-1:0];
            if (wr_ctl) begin
                src_sub <= wr_data[B_SRC];
                irq_en  <= wr_data[B_IRQEN];
                bypass  <= wr_data[B_BYPASS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tap_rise)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    // R4: an edge of the tap always leaves the flag set
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_rise |=> flag);
    // R4: a clear with no edge drops the flag
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !tap_rise) |=> !flag);
endmodule

// File: rtl/pit_divider.sv
module pit_divider
    import pit_pkg::*;
#(
    parameter int N  = STAGES,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_tick,
    input  logic          sub_tick,
    input  logic          src_sub,
    input  logic [SW-1:0] interval,
    output logic          tap_bit,
    output logic          tap_rise
);
    localparam int LAST = N - 1;

    logic [N-1:0] cnt, cnt_nxt;
    logic         adv;
    logic [N-1:0] tap_now, tap_nxt;

    always_comb begin
        adv     = src_sub ? sub_tick : sys_tick;
        cnt_nxt = cnt + 1'b1;
    end

    // one-hot tap decode: one select line per stage, last stage takes overflow values
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_tap
            logic hit;
            if (g == LAST) begin : g_last
                assign hit = (int'(interval) >= LAST);
            end else begin : g_mid
                assign hit = (int'(interval) == g);
            end
            assign tap_now[g] = hit & cnt[g];
            assign tap_nxt[g] = hit & cnt_nxt[g];
        end
    endgenerate

    always_comb begin
        tap_bit  = |tap_now;
        tap_rise = adv && !tap_bit && (|tap_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (adv)
            cnt <= cnt_nxt;
    end

    // R2: the count holds when the chosen source gives no tick
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));
    // R3: exactly one stage selected
    assert_tap_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_nxt));
endmodule

// File: rtl/pit_outsync.sv
module pit_outsync
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic sys_tick,
    input  logic tap_bit,
    output logic tmr_out
);
    sync_state_t state_q, state_d;
    logic        s1, s2;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: if (sleep)  state_d = ST_SLEEP;
            ST_SLEEP: if (!sleep) state_d = ST_AWAKE;
            default:              state_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_AWAKE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else if (sleep || state_q == ST_SLEEP) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else if (sys_tick) begin
            s1 <= tap_bit;
            s2 <= s1;
        end
    end

    always_comb begin
        tmr_out = 1'b0;
        unique case (state_q)
            ST_AWAKE: tmr_out = s2 && !sleep;
            ST_SLEEP: tmr_out = 1'b0;
            default:  tmr_out = 1'b0;
        endcase
    end

    // R7: the synchronizer comes out of a sleep state empty
    assert_sync_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> (!s1 && !s2));
    // R6: with no system tick the second flop keeps its value
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_tick && !sleep && state_q == ST_AWAKE) |=> $stable(s2));
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_tick,
    input  logic             sub_tick,
    input  logic             sleep,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic             tmr_out,
    output logic             irq_flag,
    output logic             irq_req,
    output logic             sub_tick_out
);
    logic [SEL_W-1:0] interval;
    logic src_sub, irq_en, bypass;
    logic tap_bit, tap_rise;

    pit_regs #(.SW(SEL_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tap_rise(tap_rise), .interval(interval),
        .src_sub(src_sub), .irq_en(irq_en), .bypass(bypass), .flag(irq_flag)
    );

    pit_divider #(.N(STAGES), .SW(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .sub_tick(sub_tick),
        .src_sub(src_sub), .interval(interval), .tap_bit(tap_bit),
        .tap_rise(tap_rise)
    );

    pit_outsync u_sync (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sys_tick(sys_tick),
        .tap_bit(tap_bit), .tmr_out(tmr_out)
    );

    always_comb begin
        irq_req      = irq_flag && irq_en;
        sub_tick_out = bypass ? sub_tick : tap_rise;
    end

    // R5: no request without a pending flag
    assert_req_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_flag);
    // R7: output low whenever sleep is requested
    assert_low_in_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !tmr_out);
    // R9: bypassed path mirrors the raw sub tick
    assert_bypass_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (sub_tick_out == sub_tick));
endmodule

// File: tb/sim_pit_prescaler.sv
module sim_pit_prescaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_tick = 1'b0, sub_tick = 1'b0, sleep = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic tmr_out, irq_flag, irq_req, sub_tick_out;

    int checks = 0, errors = 0;
    int sys_pct = 100, sub_pct = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_iv = 0, m_src = 0, m_en = 0, m_byp = 0, m_flag = 0;
    int m_s1 = 0, m_s2 = 0, m_asleep = 0;

    pit_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .sub_tick(sub_tick),
        .sleep(sleep), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_out(tmr_out), .irq_flag(irq_flag), .irq_req(irq_req),
        .sub_tick_out(sub_tick_out)
    );

    always #4 clk = ~clk; // 125 MHz

    function automatic int tap_idx();
        return (m_iv >= 13) ? 13 : m_iv;
    endfunction

    function automatic int model_rise();
        int adv, t, nx;
        adv = (m_src != 0) ? int'(sub_tick) : int'(sys_tick);
        t   = tap_idx();
        nx  = (m_cnt + 1) % 16384;
        return (adv != 0 && ((m_cnt >> t) & 1) == 0 && ((nx >> t) & 1) == 1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_iv = 0; m_src = 0; m_en = 0; m_byp = 0; m_flag = 0;
            m_s1 = 0; m_s2 = 0; m_asleep = 0;
        end else begin
            int rise, adv, tapv;
            rise = model_rise();
            adv  = (m_src != 0) ? int'(sub_tick) : int'(sys_tick);
            tapv = (m_cnt >> tap_idx()) & 1;
            if (sleep || m_asleep != 0) begin m_s1 = 0; m_s2 = 0; end
            else if (sys_tick) begin m_s2 = m_s1; m_s1 = tapv; end
            m_asleep = sleep ? 1 : 0;
            if (rise != 0) m_flag = 1;
            else if (wr_en && wr_addr && wr_data[3]) m_flag = 0;
            if (wr_en && !wr_addr) m_iv = int'(wr_data[3:0]);
            if (wr_en && wr_addr) begin
                m_src = int'(wr_data[0]); m_en = int'(wr_data[1]); m_byp = int'(wr_data[2]);
            end
            if (adv != 0) m_cnt = (m_cnt + 1) % 16384;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs against the model; outputs depend on current inputs too
    task automatic compare_all();
        int e_out, e_req, e_sub;
        e_out = (m_asleep == 0 && !sleep) ? m_s2 : 0;
        e_req = (m_flag != 0 && m_en != 0) ? 1 : 0;
        e_sub = (m_byp != 0) ? int'(sub_tick) : model_rise();
        chk(sleep ? "R7 tmr_out in sleep" : "R6 tmr_out", int'(tmr_out), e_out);
        chk("R4/R3/R8 irq_flag", int'(irq_flag), m_flag);
        chk("R5 irq_req", int'(irq_req), e_req);
        chk("R9 sub_tick_out", int'(sub_tick_out), e_sub);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            wr_en    = 1'b0;
            sys_tick = (($urandom % 100) < sys_pct);
            sub_tick = (($urandom % 100) < sub_pct);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        compare_all();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        sys_tick = (($urandom % 100) < sys_pct);
        sub_tick = (($urandom % 100) < sub_pct);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tmr_out", int'(tmr_out), 0);
        chk("R1 irq_flag", int'(irq_flag), 0);
        chk("R1 irq_req", int'(irq_req), 0);
        rst_n = 1'b1;
        // R1/R2: default system source, interval 0, system tick every cycle
        sys_pct = 100; sub_pct = 30;
        step(40);
        // R3: several intervals with random system ticks
        sys_pct = 60;
        for (int v = 1; v < 6; v++) begin
            write_reg(1'b0, 8'(v));
            step(150);
        end
        // R5: enable request, then clear via write-1 while edges occur
        write_reg(1'b1, 8'h02);
        step(60);
        write_reg(1'b1, 8'h0A);
        step(30);
        write_reg(1'b0, 8'h00);
        for (int k = 0; k < 20; k++) begin
            write_reg(1'b1, 8'h0A); // R4 clear racing with tap edges
            step(1);
        end
        // R2: sub-clock source; system ticks should not advance the count
        write_reg(1'b0, 8'h02);
        write_reg(1'b1, 8'h03);
        sys_pct = 50; sub_pct = 40;
        step(200);
        // R7/R8: sleep while counting from sub ticks
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); compare_all(); sleep = 1'b1;
            step(40 + k * 7);
            write_reg(1'b1, 8'h0B);
            step(10);
            @(negedge clk); compare_all(); sleep = 1'b0;
            step(25);
        end
        // R9: bypass on, then off
        write_reg(1'b1, 8'h07);
        step(80);
        write_reg(1'b1, 8'h03);
        step(80);
        // R3: last tap via values 13, 14 and 15 with continuous system ticks
        write_reg(1'b1, 8'h0A);
        sys_pct = 100; sub_pct = 20;
        write_reg(1'b0, 8'h0E);
        step(17000);
        write_reg(1'b1, 8'h0A);
        write_reg(1'b0, 8'h0F);
        step(9000);
        write_reg(1'b0, 8'h0D);
        step(9000);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule